// File: doc/BRIEF.md
# SPI Master Shift Engine with Double-Rate Clock Divider

This block is a single-chip-select SPI master. A transfer request presents a data word together with a set of transfer attributes: frame length, idle clock level, clock phase, a prescaler code, a scaler code, a double-rate bit and a continuous-clock bit. The request is held in a request register. The attributes take effect when the frame begins, so the inputs may change freely while a frame is running.

The serial clock period, in system clock cycles, is `n = (pre+1) * 2*(scl+1) / (1 + dbr)`, with a floor of 2. With the double-rate bit clear, `n` is always even and both halves of the period are equal. With the double-rate bit set, `n` may be odd, and the two halves then differ by one cycle.

The block shifts data MSB first. It returns the received bits right-aligned, together with a one-cycle completion pulse. In continuous-clock mode, the serial clock keeps toggling after the frame ends, and a new frame joins the running clock at a period boundary.

Top module: `spi_dbr_master`

## Requirements
- R1: The frame length is `cfg_fsz+1` bits. Any setting of `cfg_fsz` below 3 gives 4 bits. While `cs_n` is low, `sck` makes exactly two transitions per bit.
- R2: The serial period is `n = (cfg_pre+1)*2*(cfg_scl+1)` system cycles when `cfg_dbr`=0. In that case the active-level half and the idle-level half each last `n/2` cycles.
- R3: With `cfg_dbr`=1, the period is `n = (cfg_pre+1)*(cfg_scl+1)`, with a floor of 2. When the effective phase is 0, the active-level half lasts floor(n/2) cycles. When the effective phase is 1, it lasts ceil(n/2) cycles. The idle-level half takes the rest of the period.
- R4: `cfg_cpol` sets the idle level of `sck`: 0 idles low and 1 idles high. Outside continuous mode, `sck` rests at that level whenever no frame is running.
- R5: Effective phase 0: the slave captures on each leading edge, `mosi` changes on each trailing edge, and the MSB is on `mosi` from the moment `cs_n` falls. Effective phase 1: `mosi` changes on each leading edge and the slave captures on each trailing edge.
- R6: Bits go out MSB first, starting from bit `N-1` of `tx_data`. `rx_data` holds the N received bits right-aligned, with zeros above them.
- R7: `cs_n` falls one idle-half before the first leading edge. It rises one idle-half after the last trailing edge. `done` is a one-cycle pulse in the same cycle as the `cs_n` rise, and `rx_data` is valid from that cycle.
- R8: Changes on `cfg_*` or `tx_data` after a request has been accepted have no effect on the frame in progress.
- R9: When `cfg_cont`=1, `sck` keeps toggling with `cs_n` high after the frame. A request made during that time starts its frame at the next trailing edge. Continuous mode always behaves as phase 1.
- R10: `start` is accepted only while `busy` is low. From idle, `busy` rises on the next cycle and `cs_n` falls one cycle after that. `busy` falls with `done`. A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Transfer request |
| busy | output | 1 | Request held or frame running |
| cfg_dbr | input | 1 | Double-rate divider select |
| cfg_fsz | input | FSZ_W | Frame length minus one |
| cfg_cpol | input | 1 | Idle level of sck |
| cfg_cpha | input | 1 | Clock phase |
| cfg_cont | input | 1 | Continuous-clock mode |
| cfg_pre | input | PRE_W | Prescaler code (factor code+1) |
| cfg_scl | input | SCL_W | Scaler code (factor 2*(code+1)) |
| tx_data | input | MAX_BITS | Word to send, right-aligned |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | MAX_BITS | Received word, right-aligned |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
Sample index 0 is the falling clock edge at which `start` is driven. When the request is made from idle, `busy` is checked at index 1 and the `cs_n` fall is expected at index 2. After that, every serial-clock edge is timed against the `cs_n` fall using the idle-half and active-half lengths that the bench computes from the requirements. The first gaps and the tail gap are checked exactly. `done` must appear in exactly one sample, the same sample in which `cs_n` rises. All outputs are sampled on falling clock edges, so every register change from the preceding rising edge is already visible. A bench slave model samples at the same points and checks both data directions for each phase mode.

// File: rtl/spi_dbr_pkg.sv
package spi_dbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,  // no frame, sck parked
    ST_LEAD,  // chip select low, waiting before first edge
    ST_ACT,   // sck at active level
    ST_IDL,   // sck at idle level between bits
    ST_TAIL,  // after last edge, before chip select release
    ST_FACT,  // free-running, active level, no frame
    ST_FIDL   // free-running, idle level, no frame
  } spi_st_e;
endpackage

// File: rtl/spi_phase_calc.sv
module spi_phase_calc #(
  parameter int PRE_W = 2,
  parameter int SCL_W = 3,
  parameter int CNT_W = PRE_W + SCL_W + 2
) (
  input  logic [PRE_W-1:0] pre,
  input  logic [SCL_W-1:0] scl,
  input  logic             dbr,
  input  logic             cpha_eff,
  output logic [CNT_W-1:0] act_len,
  output logic [CNT_W-1:0] idl_len
);
  logic [CNT_W-1:0] prod, n_raw, n_cl, lo, hi;

  always_comb begin
    prod  = (CNT_W'(pre) + 1'b1) * (CNT_W'(scl) + 1'b1);
    n_raw = dbr ? prod : (prod << 1);
    n_cl  = (n_raw < CNT_W'(2)) ? CNT_W'(2) : n_raw;
    lo    = n_cl >> 1;
    hi    = n_cl - lo;
    act_len = cpha_eff ? hi : lo;
    idl_len = n_cl - act_len;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int MAX_BITS = 16,
  parameter int NB_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [MAX_BITS-1:0] load_data,
  input  logic [NB_W-1:0]     nbits,
  input  logic                cpha_eff,
  input  logic                capture,
  input  logic                launch,
  input  logic                miso,
  output logic                mosi,
  output logic [MAX_BITS-1:0] rx_word
);
  logic [MAX_BITS-1:0] tx_sr, aligned;

  assign aligned = load_data << (MAX_BITS - int'(nbits));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr   <= '0;
      rx_word <= '0;
      mosi    <= 1'b0;
    end else if (load) begin
      mosi    <= aligned[MAX_BITS-1];
      tx_sr   <= cpha_eff ? aligned : (aligned << 1);
      rx_word <= '0;
    end else begin
      if (launch) begin
        mosi  <= tx_sr[MAX_BITS-1];
        tx_sr <= tx_sr << 1;
      end
      if (capture) rx_word <= {rx_word[MAX_BITS-2:0], miso};
    end
  end

  // R5: a frame load never coincides with a data edge
  p_load_alone_r5: assert property (@(posedge clk) disable iff (rst)
    load |-> !(capture || launch));
endmodule

// File: rtl/spi_dbr_master.sv
module spi_dbr_master #(
  parameter int MAX_BITS = 16,
  parameter int FSZ_W    = $clog2(MAX_BITS),
  parameter int PRE_W    = 2,
  parameter int SCL_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  output logic                busy,
  input  logic                cfg_dbr,
  input  logic [FSZ_W-1:0]    cfg_fsz,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic                cfg_cont,
  input  logic [PRE_W-1:0]    cfg_pre,
  input  logic [SCL_W-1:0]    cfg_scl,
  input  logic [MAX_BITS-1:0] tx_data,
  output logic                done,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                sck,
  output logic                mosi,
  input  logic                miso,
  output logic                cs_n
);
  import spi_dbr_pkg::*;

  localparam int NB_W  = FSZ_W + 1;
  localparam int CNT_W = PRE_W + SCL_W + 2;

  spi_st_e st;
  logic [CNT_W-1:0] cnt, act_q, idl_q, act_new, idl_new;
  logic [NB_W-1:0]  nb_q, nb_new, bitcnt;
  logic sck_q, cs_n_q, done_q, busy_q, pend;
  logic cpol_q, cphae_q, cont_q;
  logic r_dbr, r_cpol, r_cpha, r_cont;
  logic [FSZ_W-1:0]    r_fsz;
  logic [PRE_W-1:0]    r_pre;
  logic [SCL_W-1:0]    r_scl;
  logic [MAX_BITS-1:0] r_tx, rx_q, rx_word;
  logic tick, begin_f, lead_e, trail_e, capture, launch, r_cphae;

  assign r_cphae = r_cpha | r_cont;
  assign nb_new  = (r_fsz < FSZ_W'(3)) ? NB_W'(4) : (NB_W'(r_fsz) + 1'b1);

  spi_phase_calc #(.PRE_W(PRE_W), .SCL_W(SCL_W), .CNT_W(CNT_W)) u_calc (
    .pre(r_pre), .scl(r_scl), .dbr(r_dbr), .cpha_eff(r_cphae),
    .act_len(act_new), .idl_len(idl_new)
  );

  always_comb begin
    tick    = (cnt == '0);
    begin_f = pend && ((st == ST_IDLE) || (st == ST_FACT && tick));
    lead_e  = tick && (st == ST_LEAD || st == ST_IDL);
    trail_e = tick && (st == ST_ACT);
    capture = cphae_q ? trail_e : lead_e;
    launch  = cphae_q ? lead_e : trail_e;
  end

  spi_shifter #(.MAX_BITS(MAX_BITS), .NB_W(NB_W)) u_shift (
    .clk(clk), .rst(rst), .load(begin_f), .load_data(r_tx), .nbits(nb_new),
    .cpha_eff(r_cphae), .capture(capture), .launch(launch), .miso(miso),
    .mosi(mosi), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; bitcnt <= '0;
      sck_q <= 1'b0; cs_n_q <= 1'b1; done_q <= 1'b0; busy_q <= 1'b0; pend <= 1'b0;
      cpol_q <= 1'b0; cphae_q <= 1'b0; cont_q <= 1'b0;
      nb_q <= NB_W'(4); act_q <= CNT_W'(1); idl_q <= CNT_W'(1);
      r_dbr <= 1'b0; r_cpol <= 1'b0; r_cpha <= 1'b0; r_cont <= 1'b0;
      r_fsz <= '0; r_pre <= '0; r_scl <= '0; r_tx <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        r_dbr <= cfg_dbr; r_cpol <= cfg_cpol; r_cpha <= cfg_cpha; r_cont <= cfg_cont;
        r_fsz <= cfg_fsz; r_pre <= cfg_pre; r_scl <= cfg_scl; r_tx <= tx_data;
        pend <= 1'b1; busy_q <= 1'b1;
      end
      if (begin_f) begin
        cpol_q <= r_cpol; cphae_q <= r_cphae; cont_q <= r_cont;
        nb_q <= nb_new; act_q <= act_new; idl_q <= idl_new;
        cs_n_q <= 1'b0; sck_q <= r_cpol; cnt <= idl_new - 1'b1;
        bitcnt <= '0; pend <= 1'b0; st <= ST_LEAD;
      end else if (st != ST_IDLE) begin
        if (!tick) cnt <= cnt - 1'b1;
        else begin
          case (st)
            ST_LEAD, ST_IDL: begin
              sck_q <= ~cpol_q; st <= ST_ACT; cnt <= act_q - 1'b1;
            end
            ST_ACT: begin
              sck_q <= cpol_q; cnt <= idl_q - 1'b1; bitcnt <= bitcnt + 1'b1;
              st <= (bitcnt == nb_q - 1'b1) ? ST_TAIL : ST_IDL;
            end
            ST_TAIL: begin
              cs_n_q <= 1'b1; done_q <= 1'b1; busy_q <= 1'b0; rx_q <= rx_word;
              if (cont_q) begin
                sck_q <= ~cpol_q; st <= ST_FACT; cnt <= act_q - 1'b1;
              end else st <= ST_IDLE;
            end
            ST_FACT: begin
              sck_q <= cpol_q; st <= ST_FIDL; cnt <= idl_q - 1'b1;
            end
            ST_FIDL: begin
              sck_q <= ~cpol_q; st <= ST_FACT; cnt <= act_q - 1'b1;
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign sck     = sck_q;
  assign cs_n    = cs_n_q;
  assign done    = done_q;
  assign busy    = busy_q;
  assign rx_data = rx_q;

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R7: chip select is only released together with completion
  p_cs_release_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_q) |-> done_q);
  // R4: a parked engine holds sck at the latched idle level
  p_sck_parked_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (sck_q == cpol_q));
  // R10: an accepted request raises busy
  p_busy_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q) |=> busy_q);
  // R7: no sck edge during the lead-in interval
  p_lead_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LEAD && $past(st) == ST_LEAD) |-> $stable(sck_q));
  // R1: the bit counter never passes the latched frame length
  p_bitcnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= nb_q);
endmodule

// File: tb/tb_spi_dbr_master.sv
module tb_spi_dbr_master;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT = 100000;

  typedef struct packed {
    logic dbr; logic [3:0] fsz; logic cpol; logic cpha; logic cont;
    logic [1:0] pre; logic [2:0] scl; logic [15:0] tx; logic [15:0] sl;
  } vec_t;

  localparam vec_t TBL [7] = '{
    '{1'b0, 4'd7,  1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 16'h00A5, 16'h003C},
    '{1'b0, 4'd15, 1'b1, 1'b1, 1'b0, 2'd1, 3'd1, 16'hBEEF, 16'h1234},
    '{1'b1, 4'd11, 1'b0, 1'b0, 1'b0, 2'd2, 3'd0, 16'h0ABC, 16'h0F0F},
    '{1'b1, 4'd4,  1'b1, 1'b1, 1'b0, 2'd2, 3'd0, 16'h0013, 16'h000A},
    '{1'b1, 4'd1,  1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 16'hFFFF, 16'h0005},
    '{1'b1, 4'd9,  1'b1, 1'b0, 1'b0, 2'd2, 3'd1, 16'h0155, 16'h02AA},
    '{1'b0, 4'd6,  1'b0, 1'b1, 1'b0, 2'd3, 3'd2, 16'h005A, 16'h0021}
  };
  localparam vec_t V_CONT = '{1'b0, 4'd7, 1'b0, 1'b0, 1'b1, 2'd0, 3'd1, 16'h00C3, 16'h0096};
  localparam vec_t V_JOIN = '{1'b0, 4'd5, 1'b0, 1'b0, 1'b0, 2'd1, 3'd0, 16'h002D, 16'h0011};

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, miso = 1'b0;
  logic cfg_dbr = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_cont = 1'b0;
  logic [3:0] cfg_fsz = '0; logic [1:0] cfg_pre = '0; logic [2:0] cfg_scl = '0;
  logic [15:0] tx_data = '0;
  logic busy, done, sck, mosi, cs_n;
  logic [15:0] rx_data;

  int checks = 0, fails = 0, wd = 0;

  // slave model state
  logic s_cpol = 1'b0, s_cpha = 1'b0, s_psck = 1'b0, s_pcs = 1'b1;
  int s_nb = 4;
  logic [15:0] s_pat = '0, s_sr = '0, s_rcv = '0;

  spi_dbr_master dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .cfg_dbr(cfg_dbr),
    .cfg_fsz(cfg_fsz), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_cont(cfg_cont),
    .cfg_pre(cfg_pre), .cfg_scl(cfg_scl), .tx_data(tx_data), .done(done),
    .rx_data(rx_data), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst) begin
      s_psck = sck; s_pcs = 1'b1;
    end else begin
      if (s_pcs && !cs_n) begin
        s_sr = s_pat << (16 - s_nb);
        s_rcv = '0;
        if (!s_cpha) begin miso = s_sr[15]; s_sr = s_sr << 1; end
      end else if (!cs_n && sck != s_psck) begin
        if ((sck != s_cpol) != s_cpha) s_rcv = {s_rcv[14:0], mosi};
        else begin miso = s_sr[15]; s_sr = s_sr << 1; end
      end
      s_psck = sck; s_pcs = cs_n;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", wd, WD_LIMIT);
      summary();
    end
  end

  task automatic drive_cfg(input vec_t v);
    cfg_dbr = v.dbr; cfg_fsz = v.fsz; cfg_cpol = v.cpol; cfg_cpha = v.cpha;
    cfg_cont = v.cont; cfg_pre = v.pre; cfg_scl = v.scl; tx_data = v.tx;
  endtask

  task automatic run_frame(input vec_t v, input bit from_idle, input bit perturb, input bit dbl);
    int p, n, act, idl, nb, smp, csf, csr, e_cnt, dn_cnt, dn_at, last_e;
    int et [3];
    logic psck, pcs, cphae;
    logic [15:0] mask;
    p = int'(v.pre) + 1;
    n = v.dbr ? p * (int'(v.scl) + 1) : 2 * p * (int'(v.scl) + 1);
    if (n < 2) n = 2;
    cphae = v.cpha | v.cont;
    act = cphae ? n - n / 2 : n / 2;
    idl = n - act;
    nb = (v.fsz < 3) ? 4 : int'(v.fsz) + 1;
    mask = 16'((32'd1 << nb) - 1);
    @(negedge clk);
    s_cpol = v.cpol; s_cpha = cphae; s_nb = nb; s_pat = v.sl;
    drive_cfg(v); start = 1'b1;
    psck = sck; pcs = cs_n;
    csf = -1; csr = -1; e_cnt = 0; dn_cnt = 0; dn_at = -1; last_e = -1;
    et[0] = -1; et[1] = -1; et[2] = -1;
    @(negedge clk); start = 1'b0; smp = 1;
    if (from_idle) chk("R10 busy after accept", int'(busy), 1);
    while (csr < 0 && smp < 3000) begin
      if (pcs && !cs_n) csf = smp;
      else if (!cs_n && sck != psck) begin
        if (e_cnt < 3) et[e_cnt] = smp;
        last_e = smp; e_cnt++;
      end
      if (!pcs && cs_n) csr = smp;
      if (done) begin dn_cnt++; dn_at = smp; end
      psck = sck; pcs = cs_n;
      if (perturb && smp == 6) begin
        cfg_cpol = ~v.cpol; cfg_fsz = 4'd15; cfg_pre = 2'd3; cfg_dbr = ~v.dbr; tx_data = ~v.tx;
      end
      if (dbl && smp == 5) begin tx_data = 16'h5555; start = 1'b1; end
      if (dbl && smp == 6) start = 1'b0;
      @(negedge clk); smp++;
    end
    if (from_idle) chk("R10 cs_n fall two samples after start", csf, 2);
    chk("R1 sck transitions in frame", e_cnt, 2 * nb);
    chk("R7 lead-in gap", et[0] - csf, idl);
    chk("R2 R3 active half", et[1] - et[0], act);
    chk("R2 R3 idle half", et[2] - et[1], idl);
    chk("R7 tail gap", csr - last_e, idl);
    chk("R7 done single pulse", dn_cnt, 1);
    chk("R7 done with cs_n rise", dn_at, csr);
    chk("R6 rx_data right-aligned", int'(rx_data), int'(v.sl & mask));
    chk("R5 R6 slave received", int'(s_rcv & mask), int'(v.tx & mask));
    chk("R7 done drops", int'(done), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 reset cs_n", int'(cs_n), 1);
    chk("R4 reset sck", int'(sck), 0);
    chk("R7 reset done", int'(done), 0);
    chk("R10 reset busy", int'(busy), 0);

    for (int i = 0; i < 7; i++) begin
      run_frame(TBL[i], 1'b1, 1'b0, 1'b0);
      chk("R4 sck parked at cpol", int'(sck), int'(TBL[i].cpol));
    end

    // R8: input changes during the frame
    run_frame(TBL[0], 1'b1, 1'b1, 1'b0);
    // R10: start while busy is ignored
    run_frame(TBL[1], 1'b1, 1'b0, 1'b1);
    begin
      int extra_fall;
      logic pc;
      extra_fall = 0; pc = cs_n;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (pc && !cs_n) extra_fall++;
        pc = cs_n;
      end
      chk("R10 ignored start launched no frame", extra_fall, 0);
      chk("R10 busy low after ignored start", int'(busy), 0);
    end

    // R9: continuous mode, phase forced to 1 even though cfg_cpha=0
    run_frame(V_CONT, 1'b1, 1'b0, 1'b0);
    begin
      int tog;
      logic ps;
      tog = 0; ps = sck;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (cs_n && sck != ps) tog++;
        ps = sck;
      end
      chk("R9 free-running toggles", int'(tog >= 4), 1);
    end
    run_frame(V_JOIN, 1'b0, 1'b0, 1'b0);
    begin
      int moves;
      moves = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (sck != V_JOIN.cpol || !cs_n) moves++;
      end
      chk("R9 R4 clock stops after non-continuous frame", moves, 0);
    end

    summary();
  end
endmodule